// File: doc/BRIEF.md
# Instrument Status Reporting Register Group

This block keeps the status reporting state of a remotely programmed instrument. Single-cycle event pulses from the rest of the instrument set bits in an 8-bit sticky event register. An 8-bit event enable mask picks which of those bits count, and their masked OR becomes the event summary in bit 5 of the status byte. The other status byte positions come from summary inputs that other register groups drive. A service-request enable mask chooses which status byte bits can ask for service. When that enabled condition rises, the request-service bit (status byte bit 6) is set and the SRQ output goes high.

A command decoder reaches the four registers through a small port with an address, a write strobe and a read strobe. Reads are combinational in the strobe cycle. Any clear that a read causes takes effect at the next clock edge. Three command strobes are also provided: clear-status, a reset strobe and serial poll. Serial poll returns the status byte and clears the request-service bit.

Top module: `stat_report_top`

## Requirements
- R1: A bit of the event register (address 0) is set by a one-cycle pulse on its `evt_pulse` line. It stays set through later pulses or idle cycles until one of the clears in R2 or R4.
- R2: A read strobe at address 0 returns the event register on `reg_rdata` in that cycle and clears all its bits at the following edge. Writes to address 0 have no effect.
- R3: If an event pulse arrives in the same cycle as a read-and-clear of the event register, that bit is set after the clear.
- R4: `clr_stat` clears the event register and the request-service bit. It leaves the event enable (address 1) and service-request enable (address 3) registers unchanged.
- R5: `soft_rst` clears the request-service bit. It leaves the event, event enable and service-request enable registers unchanged.
- R6: The event enable register at address 1 is written with `reg_wdata` and reads back the written value. Reading it never changes it.
- R7: Status byte bit 5 equals the OR over all eight positions of (event bit AND event enable bit).
- R8: The service-request enable register at address 3 stores every written bit except bit 6, which always reads 0. Readback therefore lies in 0–63 or 128–191.
- R9: A read at address 2 and a serial poll return the same status byte value. Only the serial poll clears bit 6, and `srq` follows bit 6.
- R10: Bit 6 is set only at the edge after a rising edge of the service condition, which is the OR of the status byte bits other than bit 6 ANDed with their service-request enable bits. A condition that stays true after a clear does not set bit 6 again.
- R11: Status byte bits 0–4 and 7 mirror `ext_sum` at the same positions. `ext_sum` bits 5 and 6 are ignored.
- R12: After power-up reset every register reads 0 and `srq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| evt_pulse | input | 8 | One-cycle event condition pulses |
| ext_sum | input | 8 | Summary bits from other register groups |
| reg_addr | input | 2 | Register select: 0 event, 1 event enable, 2 status byte, 3 service-request enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears the event register at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the addressed register |
| clr_stat | input | 1 | Clear-status strobe |
| soft_rst | input | 1 | Reset command strobe |
| spoll | input | 1 | Serial poll strobe |
| poll_data | output | 8 | Status byte as returned by a poll |
| srq | output | 1 | Service request output |

## Verification
The bench sweeps every event enable value against a spread of event patterns and checks the bit 5 summary and the read-and-clear each time. It also sweeps every service-request enable write and every external summary value, so a masking slip or a swapped bit position shows up as a wrong byte. It aims at a read colliding with a new event, where a design that clears after it merges would lose the event. It also checks that a status byte read leaves bit 6 intact, where a design that treats the read like a poll would drop the request. After a poll or a reset strobe it holds the enabled condition true. A design that sets bit 6 from the level instead of the rising edge would raise `srq` again at once.

// File: rtl/stat_report_pkg.sv
package stat_report_pkg;
    localparam int REG_W   = 8;
    localparam int ESB_POS = 5;   // event summary position in the status byte
    localparam int RQS_POS = 6;   // request-service position in the status byte

    typedef enum logic [1:0] {
        ADDR_EVT    = 2'd0,
        ADDR_EVT_EN = 2'd1,
        ADDR_STB    = 2'd2,
        ADDR_SRE    = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/evt_group.sv
module evt_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    input  logic         rd_clr,
    input  logic         clr_all,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] en_q,
    output logic         summary
);
    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] en;
    } grp_t;

    grp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // R2, R4: clear on read or clear-status
        if (rd_clr || clr_all) begin
            st_d.evt = '0;
        end
        // R1, R3: new events merge after the clear, so none is lost
        st_d.evt = st_d.evt | evt_in;
        // R6: enable mask is plain read/write
        if (en_wr) begin
            st_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_q   = st_q.evt;
    assign en_q    = st_q.en;
    // R7: masked OR roll-up
    assign summary = |(st_q.evt & st_q.en);
endmodule

// File: rtl/srq_gen.sv
module srq_gen #(
    parameter int W       = 8,
    parameter int ESB_POS = 5,
    parameter int RQS_POS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_sum,
    input  logic         esb,
    input  logic         sre_wr,
    input  logic [W-1:0] sre_wdata,
    input  logic         poll,
    input  logic         clr_all,
    input  logic         soft_rst,
    output logic [W-1:0] sre_q,
    output logic [W-1:0] stb,
    output logic         rqs
);
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ESB_MASK = ONE << ESB_POS;
    localparam logic [W-1:0] RQS_MASK = ONE << RQS_POS;

    typedef struct packed {
        logic [W-1:0] sre;
        logic         rqs;
        logic         svc_prev;
    } srq_t;

    srq_t st_d, st_q;
    logic [W-1:0] stb_base;
    logic         svc;
    logic         svc_rise;

    always_comb begin
        // R11: external bits except the summary and request positions
        stb_base = ext_sum & ~(ESB_MASK | RQS_MASK);
        // R7: event summary drives its own position
        stb_base = stb_base | (esb ? ESB_MASK : '0);
        // R10: enabled condition and its rising edge
        svc      = |(stb_base & st_q.sre);
        svc_rise = svc && !st_q.svc_prev;

        st_d          = st_q;
        st_d.svc_prev = svc;
        // R8: request position of the enable mask is never stored
        if (sre_wr) begin
            st_d.sre = sre_wdata & ~RQS_MASK;
        end
        // R4, R5, R9: clears of the request bit
        if (poll || clr_all || soft_rst) begin
            st_d.rqs = 1'b0;
        end
        // R10: a fresh rising edge wins over a clear in the same cycle
        if (svc_rise) begin
            st_d.rqs = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sre_q = st_q.sre;
    assign rqs   = st_q.rqs;
    assign stb   = stb_base | (st_q.rqs ? RQS_MASK : '0);
endmodule

// File: rtl/stat_report_top.sv
module stat_report_top
    import stat_report_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic [REG_W-1:0] ext_sum,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             clr_stat,
    input  logic             soft_rst,
    input  logic             spoll,
    output logic [REG_W-1:0] poll_data,
    output logic             srq
);
    logic [REG_W-1:0] esr_w;
    logic [REG_W-1:0] ese_w;
    logic [REG_W-1:0] sre_w;
    logic [REG_W-1:0] stb_w;
    logic             esb_w;
    logic             rqs_w;
    logic             esr_rd;
    logic             ese_wr;
    logic             sre_wr;
    reg_addr_e        sel;

    always_comb begin
        sel    = reg_addr_e'(reg_addr);
        esr_rd = reg_rd && (sel == ADDR_EVT);
        ese_wr = reg_wr && (sel == ADDR_EVT_EN);
        sre_wr = reg_wr && (sel == ADDR_SRE);
    end

    evt_group #(.W(REG_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_pulse),
        .rd_clr   (esr_rd),
        .clr_all  (clr_stat),
        .en_wr    (ese_wr),
        .en_wdata (reg_wdata),
        .evt_q    (esr_w),
        .en_q     (ese_w),
        .summary  (esb_w)
    );

    srq_gen #(.W(REG_W), .ESB_POS(ESB_POS), .RQS_POS(RQS_POS)) u_srq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sum   (ext_sum),
        .esb       (esb_w),
        .sre_wr    (sre_wr),
        .sre_wdata (reg_wdata),
        .poll      (spoll),
        .clr_all   (clr_stat),
        .soft_rst  (soft_rst),
        .sre_q     (sre_w),
        .stb       (stb_w),
        .rqs       (rqs_w)
    );

    // R9: status byte read and poll share one source
    always_comb begin
        unique case (sel)
            ADDR_EVT:    reg_rdata = esr_w;
            ADDR_EVT_EN: reg_rdata = ese_w;
            ADDR_STB:    reg_rdata = stb_w;
            default:     reg_rdata = sre_w;
        endcase
    end

    assign poll_data = stb_w;
    assign srq       = rqs_w;
endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_pulse,
    input logic [1:0]   reg_addr,
    input logic         reg_wr,
    input logic         reg_rd,
    input logic         clr_stat,
    input logic         soft_rst,
    input logic         spoll,
    input logic [W-1:0] poll_data,
    input logic         srq,
    input logic [W-1:0] esr_w,
    input logic [W-1:0] ese_w,
    input logic [W-1:0] sre_w
);
    logic rd_evt;
    logic wr_en;
    assign rd_evt = reg_rd && (reg_addr == 2'd0);
    assign wr_en  = reg_wr && (reg_addr == 2'd1);

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_evt && !clr_stat) |=> ((esr_w & $past(esr_w)) == $past(esr_w)));

    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (esr_w == $past(evt_pulse)));

    p_clrstat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (esr_w == $past(evt_pulse)));

    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ese_w));

    p_softrst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !reg_wr) |=> ($stable(ese_w) && $stable(sre_w)));

    p_sre_bit6_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sre_w[6] == 1'b0);

    p_srq_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srq == poll_data[6]);

    p_srq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srq) |-> $past(spoll || clr_stat || soft_rst));
endmodule

bind stat_report_top stat_report_chk #(.W(8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .clr_stat  (clr_stat),
    .soft_rst  (soft_rst),
    .spoll     (spoll),
    .poll_data (poll_data),
    .srq       (srq),
    .esr_w     (esr_w),
    .ese_w     (ese_w),
    .sre_w     (sre_w)
);

// File: tb/tb_stat_report_top.sv
module tb_stat_report_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_pulse = '0;
    logic [7:0] ext_sum = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       clr_stat = 1'b0;
    logic       soft_rst = 1'b0;
    logic       spoll = 1'b0;
    logic [7:0] poll_data;
    logic       srq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    stat_report_top dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ext_sum(ext_sum),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_stat(clr_stat),
        .soft_rst(soft_rst), .spoll(spoll), .poll_data(poll_data), .srq(srq)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic ev(input logic [7:0] v);
        evt_pulse = v;
        tick();
        evt_pulse = '0;
    endtask

    task automatic poll(output logic [7:0] v);
        spoll = 1'b1;
        #1 v = poll_data;
        tick();
        spoll = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pat;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R12: power-up state
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], v);
            check("R12 reset register", v, 8'h00);
        end
        check("R12 reset srq", {7'd0, srq}, 8'h00);

        // R1: sticky bits, repeats ignored
        ev(8'h08); ev(8'h08); tick(); ev(8'h01);
        rd(2'd0, v);
        check("R1 sticky event", v, 8'h09);
        rd(2'd0, v);
        check("R2 read clears", v, 8'h00);
        // R2: writes to the event register do nothing
        wr(2'd0, 8'hFF);
        peek(2'd0, v);
        check("R2 write ignored", v, 8'h00);

        // R3: event coinciding with read-and-clear survives
        ev(8'h02);
        reg_addr = 2'd0; reg_rd = 1'b1; evt_pulse = 8'h20;
        #1 v = reg_rdata;
        tick();
        reg_rd = 1'b0; evt_pulse = '0;
        check("R3 read value", v, 8'h02);
        rd(2'd0, v);
        check("R3 event kept", v, 8'h20);

        // R6: enable readback is non-destructive
        wr(2'd1, 8'hA5);
        rd(2'd1, v);
        check("R6 enable read", v, 8'hA5);
        rd(2'd1, v);
        check("R6 enable read again", v, 8'hA5);

        // R4: clear-status hits events only
        wr(2'd3, 8'h12);
        ev(8'h44);
        clr_stat = 1'b1; tick(); clr_stat = 1'b0;
        peek(2'd0, v); check("R4 events cleared", v, 8'h00);
        peek(2'd1, v); check("R4 event enable kept", v, 8'hA5);
        peek(2'd3, v); check("R4 request enable kept", v, 8'h12);

        // R5: reset strobe keeps registers, drops request
        ev(8'h03);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h20);
        tick(); tick();
        check("R10 srq on rising condition", {7'd0, srq}, 8'h01);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check("R5 srq cleared", {7'd0, srq}, 8'h00);
        peek(2'd0, v); check("R5 events kept", v, 8'h03);
        peek(2'd1, v); check("R5 event enable kept", v, 8'h01);
        peek(2'd3, v); check("R5 request enable kept", v, 8'h20);
        tick(); tick(); tick();
        check("R10 no re-request on level", {7'd0, srq}, 8'h00);

        // R9 / R10: re-arm, status byte read vs poll
        wr(2'd1, 8'h00); tick();
        wr(2'd1, 8'h01); tick(); tick();
        check("R10 srq after new edge", {7'd0, srq}, 8'h01);
        rd(2'd2, v);
        check("R9 status byte read", v, 8'h60);
        check("R9 read keeps srq", {7'd0, srq}, 8'h01);
        poll(v);
        check("R9 poll value", v, 8'h60);
        check("R9 poll clears srq", {7'd0, srq}, 8'h00);
        peek(2'd2, v);
        check("R9 bit6 cleared by poll", v, 8'h20);
        tick(); tick(); tick();
        check("R10 stays clear while level holds", {7'd0, srq}, 8'h00);

        // clean up
        rd(2'd0, v);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h00);
        tick();

        // R8: every write to the request enable
        for (int i = 0; i < 256; i++) begin
            wr(2'd3, i[7:0]);
            peek(2'd3, v);
            check("R8 request enable bit6", v, i[7:0] & 8'hBF);
        end
        wr(2'd3, 8'h00);
        tick();

        // R7 / R2: summary sweep
        for (int e = 0; e < 256; e++) begin
            wr(2'd1, e[7:0]);
            for (int k = 0; k < 8; k++) begin
                pat = (e[7:0] * 8'd7) + (k[7:0] * 8'd29) + 8'd1;
                ev(pat);
                peek(2'd2, v);
                check("R7 summary bit5", v, ((e[7:0] & pat) != 0) ? 8'h20 : 8'h00);
                rd(2'd0, v);
                check("R2 read value", v, pat);
            end
        end
        wr(2'd1, 8'h00);

        // R11: external summary placement
        for (int x = 0; x < 256; x++) begin
            ext_sum = x[7:0];
            peek(2'd2, v);
            check("R11 external bits", v, x[7:0] & 8'h9F);
        end
        ext_sum = 8'h00; tick();
        wr(2'd3, 8'h01); tick();
        ext_sum = 8'h01; tick(); tick();
        check("R11 external request", {7'd0, srq}, 8'h01);
        poll(v);
        check("R11 poll value", v, 8'h41);

        // R4: clear-status drops a pending request
        ext_sum = 8'h00; tick(); tick();
        ext_sum = 8'h01; tick(); tick();
        check("R4 request pending", {7'd0, srq}, 8'h01);
        clr_stat = 1'b1; tick(); clr_stat = 1'b0;
        check("R4 request cleared", {7'd0, srq}, 8'h00);

        // R11: ext bits 5 and 6 cannot request
        ext_sum = 8'h00; wr(2'd3, 8'hFF); tick();
        ext_sum = 8'h60; tick(); tick(); tick();
        check("R11 ignored bits no request", {7'd0, srq}, 8'h00);
        peek(2'd2, v);
        check("R11 ignored bits hidden", v, 8'h00);

        finish_run();
    end
endmodule